// File: doc/BRIEF.md
# Dual Selectable-Input Serial Shift Register

Two independent serial-in shift registers sit side by side and share an active-low asynchronous clear and one data-select line. Each register advances when its own effective clock rises. That effective clock is the OR of a clock-pulse input common to both registers and a clock-pulse input private to that register. A steady high on either of the two inputs therefore freezes the register.

The serial input of each register comes from a two-way selector over a pair of data bits. The shared select line picks the pair member for both registers at once. Each register presents its final stage in both true and inverted form. There is no parallel output and no parallel load.

The clock-pulse inputs are slow control signals, not real clocks. The block samples them on a free-running system clock through a synchronizer and turns each rise of an effective clock into a single-cycle shift strobe. Register count, stage count and synchronizer depth are parameters.

Top module: `dual_sel_shifter`

## Requirements
- R1: Each of the NUM_CH registers (default 2) holds STAGES bits (default 8). The serial bit taken on a shift reaches the tail output after STAGES shifts.
- R2: A register's effective clock is the OR of `cp_common` and its own bit of `cp_lane`. A rise of either input, or of both together, from an all-low state shifts that register exactly once.
- R3: While either clock input of a register is high, that register holds its contents. A pulse on the other input causes no shift.
- R4: The serial bit of register i is `din_a[i]` when `sel` is 0 and `din_b[i]` when `sel` is 1. One `sel` line serves all registers.
- R5: `tail_n[i]` is always the complement of `tail[i]`.
- R6: While `rst_n` is low, every stage of every register is 0 at once, without any system clock edge, whatever the other inputs are.
- R7: With the default SYNC_STAGES of 2, a clock-input rise applied between system clock edges changes the tail at the third rising system clock edge after it, and not before.
- R8: A clock input that is already high when reset is released causes no shift. It must first go low and then high again.
- R9: On a shift, stage 0 takes the selected serial bit and every stage k takes the old stage k-1. The tail is the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous clear, active low, shared by all registers |
| cp_common | input | 1 | Clock-pulse input shared by all registers |
| cp_lane | input | NUM_CH | Private clock-pulse input, one bit per register |
| sel | input | 1 | Data select: 0 picks `din_a`, 1 picks `din_b` |
| din_a | input | NUM_CH | First serial data candidate, one bit per register |
| din_b | input | NUM_CH | Second serial data candidate, one bit per register |
| tail | output | NUM_CH | Last stage of each register |
| tail_n | output | NUM_CH | Inverted last stage of each register |

## Verification
The bench builds the block with its defaults: two registers of eight stages and a two-flop synchronizer. Two registers are enough to separate shared clocking from private clocking and from inhibit. Eight stages mean a bit pattern passes through the whole register in a short run. The two-flop depth fixes the three-edge latency that the cycle-exact check expects, and it is the depth at which a clock input left high across reset release would show up as a stray shift.

// File: rtl/dss_pkg.sv
package dss_pkg;

   typedef enum logic {
      PICK_A = 1'b0,
      PICK_B = 1'b1
   } dss_pick_e;

   function automatic logic dss_pick(input dss_pick_e which, input logic a, input logic b);
      return (which == PICK_B) ? b : a;
   endfunction

endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
   parameter int W     = 3,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         dout_ok
);

   generate
      if (DEPTH == 0) begin : g_bypass
         assign dout    = din;
         assign dout_ok = 1'b1;
      end else begin : g_chain
         logic [DEPTH-1:0][W-1:0] stg;
         logic [DEPTH-1:0]        ok;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg <= '0;
               ok  <= '0;
            end else begin
               stg[0] <= din;
               ok[0]  <= 1'b1;
               for (int k = 1; k < DEPTH; k++) begin
                  stg[k] <= stg[k-1];
                  ok[k]  <= ok[k-1];
               end
            end
         end

         assign dout    = stg[DEPTH-1];
         assign dout_ok = ok[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/dss_rise.sv
module dss_rise #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic         lvl_ok,
   output logic [W-1:0] rise
);

   logic [W-1:0] prev;
   logic         prev_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev    <= '0;
         prev_ok <= 1'b0;
      end else begin
         prev    <= lvl;
         prev_ok <= lvl_ok;
      end
   end

   // a rise counts only when the previous sample was itself valid data
   assign rise = prev_ok ? (lvl & ~prev) : '0;

endmodule

// File: rtl/dss_lane.sv
module dss_lane
   import dss_pkg::*;
#(
   parameter int STAGES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift,
   input  logic sel,
   input  logic d_a,
   input  logic d_b,
   output logic head,
   output logic pen,
   output logic tail
);

   logic [STAGES-1:0] st;
   logic              sd;

   assign sd = dss_pick(dss_pick_e'(sel), d_a, d_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else if (shift) begin
         st <= {st[STAGES-2:0], sd};
      end
   end

   assign head = st[0];
   assign pen  = st[STAGES-2];
   assign tail = st[STAGES-1];

endmodule

// File: rtl/dual_sel_shifter.sv
module dual_sel_shifter #(
   parameter int NUM_CH      = 2,
   parameter int STAGES      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cp_common,
   input  logic [NUM_CH-1:0] cp_lane,
   input  logic              sel,
   input  logic [NUM_CH-1:0] din_a,
   input  logic [NUM_CH-1:0] din_b,
   output logic [NUM_CH-1:0] tail,
   output logic [NUM_CH-1:0] tail_n
);

   localparam int CPW = NUM_CH + 1;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("dual_sel_shifter: NUM_CH must be at least 1");
      end
      if (STAGES < 2) begin : g_bad_st
         $error("dual_sel_shifter: STAGES must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sy
         $error("dual_sel_shifter: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [CPW-1:0]    cp_raw;
   logic [CPW-1:0]    cp_sync;
   logic              cp_ok;
   logic              s_common;
   logic [NUM_CH-1:0] s_lane;
   logic [NUM_CH-1:0] eff;
   logic [NUM_CH-1:0] shift_en;
   logic [NUM_CH-1:0] head_v;
   logic [NUM_CH-1:0] pen_v;

   assign cp_raw = {cp_lane, cp_common};

   dss_sync #(.W(CPW), .DEPTH(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (cp_raw),
      .dout    (cp_sync),
      .dout_ok (cp_ok)
   );

   assign s_common = cp_sync[0];
   assign s_lane   = cp_sync[CPW-1:1];
   assign eff      = s_lane | {NUM_CH{s_common}};

   dss_rise #(.W(NUM_CH)) u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (eff),
      .lvl_ok (cp_ok),
      .rise   (shift_en)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
         dss_lane #(.STAGES(STAGES)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .shift (shift_en[i]),
            .sel   (sel),
            .d_a   (din_a[i]),
            .d_b   (din_b[i]),
            .head  (head_v[i]),
            .pen   (pen_v[i]),
            .tail  (tail[i])
         );
      end
   endgenerate

   assign tail_n = ~tail;

endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic [NUM_CH-1:0] din_a,
   input logic [NUM_CH-1:0] din_b,
   input logic              s_common,
   input logic [NUM_CH-1:0] s_lane,
   input logic [NUM_CH-1:0] shift_en,
   input logic [NUM_CH-1:0] head_v,
   input logic [NUM_CH-1:0] pen_v,
   input logic [NUM_CH-1:0] tail
);

   // R6: cleared while reset is held
   assert_reset_clear_R6: assert property (@(posedge clk) !rst_n |-> tail == '0);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R2: one shift per rise, never two cycles in a row
      assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
         shift_en[i] |=> !shift_en[i]);

      // R3: an input that stayed high blocks any shift
      assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
         ((s_common || s_lane[i]) && $past(s_common || s_lane[i])) |-> !shift_en[i]);

      // R9: tail takes the stage before it
      assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
         shift_en[i] |=> tail[i] == $past(pen_v[i]));

      // R4: stage 0 takes the selected data bit
      assert_mux_R4: assert property (@(posedge clk) disable iff (!rst_n)
         shift_en[i] |=> head_v[i] == $past(sel ? din_b[i] : din_a[i]));

      // R3: without a strobe the tail holds
      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         !shift_en[i] |=> $stable(tail[i]));
   end

endmodule

bind dual_sel_shifter dss_checker #(.NUM_CH(NUM_CH)) u_dss_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel      (sel),
   .din_a    (din_a),
   .din_b    (din_b),
   .s_common (s_common),
   .s_lane   (s_lane),
   .shift_en (shift_en),
   .head_v   (head_v),
   .pen_v    (pen_v),
   .tail     (tail)
);

// File: tb/test_dual_sel_shifter.sv
module test_dual_sel_shifter;

   localparam int NC = 2;
   localparam int ST = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cp_common = 1'b0;
   logic [NC-1:0] cp_lane = '0;
   logic          sel = 1'b0;
   logic [NC-1:0] din_a = '0;
   logic [NC-1:0] din_b = '0;
   logic [NC-1:0] tail;
   logic [NC-1:0] tail_n;

   always #2 clk = ~clk;

   dual_sel_shifter #(.NUM_CH(NC), .STAGES(ST), .SYNC_STAGES(2)) i_dual_sel_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .cp_common (cp_common),
      .cp_lane   (cp_lane),
      .sel       (sel),
      .din_a     (din_a),
      .din_b     (din_b),
      .tail      (tail),
      .tail_n    (tail_n)
   );

   typedef struct {
      int    lane;
      logic  q;
      string req;
   } exp_t;

   exp_t          exp_q[$];
   logic [ST-1:0] mdl [NC];
   int            n_chk = 0;
   int            n_fail = 0;
   bit            done = 1'b0;

   task automatic chk_bit(string req, string what, logic act, logic expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, expv, $time);
      end
   endtask

   // monitor: pops expected items and compares at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk_bit(e.req, $sformatf("tail[%0d]", e.lane), tail[e.lane], e.q);
            chk_bit("R5", $sformatf("tail_n[%0d]", e.lane), tail_n[e.lane], ~e.q);
         end
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_exp(string req);
      for (int l = 0; l < NC; l++) begin
         exp_t e;
         e.lane = l;
         e.q    = mdl[l][ST-1];
         e.req  = req;
         exp_q.push_back(e);
      end
   endtask

   task automatic set_data(logic s, logic [NC-1:0] a, logic [NC-1:0] b);
      sel   = s;
      din_a = a;
      din_b = b;
      idle(1);
   endtask

   // apply new clock-input levels; model shifts lanes whose OR rises
   task automatic drive_lv(logic com, logic [NC-1:0] lane);
      for (int l = 0; l < NC; l++) begin
         logic was, now, sd;
         was = cp_common | cp_lane[l];
         now = com | lane[l];
         sd  = sel ? din_b[l] : din_a[l];
         if (!was && now) mdl[l] = {mdl[l][ST-2:0], sd};
      end
      cp_common = com;
      cp_lane   = lane;
      idle(5);
   endtask

   task automatic pulse(logic com, logic [NC-1:0] lane, logic [NC-1:0] hold, string req);
      drive_lv(com, lane | hold);
      drive_lv(1'b0, hold);
      push_exp(req);
      idle(1);
   endtask

   task automatic clear_model();
      for (int l = 0; l < NC; l++) mdl[l] = '0;
   endtask

   initial begin
      clear_model();
      idle(3);
      // R6 / R5: reset state
      chk_bit("R6", "tail in reset", tail[0] | tail[1], 1'b0);
      chk_bit("R5", "tail_n in reset", tail_n[0] & tail_n[1], 1'b1);
      rst_n = 1'b1;
      idle(4);

      // R1 / R9: distinct serial patterns on each lane, shared clock
      for (int k = 0; k < 12; k++) begin
         logic [7:0] p0, p1;
         p0 = 8'b1011_0010;
         p1 = 8'b0110_1101;
         set_data(1'b0, {p1[k%8], p0[k%8]}, {~p1[k%8], ~p0[k%8]});
         pulse(1'b1, '0, '0, "R1_R9");
      end

      // R4: select the second candidate
      for (int k = 0; k < 9; k++) begin
         set_data(1'b1, {k[0], ~k[1]}, {k[1], k[0]});
         pulse(1'b1, '0, '0, "R4");
      end
      set_data(1'b0, 2'b10, 2'b01);
      pulse(1'b1, '0, '0, "R4");

      // R2: private clock of lane 1 only, lane 0 untouched
      for (int k = 0; k < 5; k++) begin
         set_data(1'b0, {k[0], 1'b1}, 2'b00);
         pulse(1'b0, 2'b10, '0, "R2");
      end
      // R2: private clock of lane 0 only
      for (int k = 0; k < 3; k++) begin
         set_data(1'b1, 2'b00, {1'b1, ~k[0]});
         pulse(1'b0, 2'b01, '0, "R2");
      end

      // R3: lane 0 private input held high inhibits it
      set_data(1'b0, 2'b11, 2'b00);
      drive_lv(1'b0, 2'b01);
      push_exp("R3");
      for (int k = 0; k < 6; k++) begin
         set_data(1'b0, {k[0], ~k[0]}, 2'b00);
         pulse(1'b1, '0, 2'b01, "R3");
      end
      drive_lv(1'b0, 2'b00);
      push_exp("R3");

      // R2: overlapping rises give one shift only
      set_data(1'b1, 2'b00, 2'b11);
      drive_lv(1'b1, 2'b00);
      drive_lv(1'b1, 2'b11);
      drive_lv(1'b0, 2'b11);
      drive_lv(1'b0, 2'b00);
      push_exp("R2");
      idle(1);

      // alternating fill so the last two stages differ
      for (int k = 0; k < 8; k++) begin
         set_data(1'b0, {~k[0], k[0]}, 2'b00);
         pulse(1'b1, '0, '0, "R1");
      end

      // R7: exact latency of a shift
      set_data(1'b0, 2'b01, 2'b00);
      begin
         logic [NC-1:0] old_t, new_t;
         for (int l = 0; l < NC; l++) begin
            old_t[l] = mdl[l][ST-1];
            new_t[l] = mdl[l][ST-2];
            mdl[l]   = {mdl[l][ST-2:0], din_a[l]};
         end
         cp_common = 1'b1;
         @(negedge clk);
         @(negedge clk);
         chk_bit("R7", "tail after two edges", tail[0], old_t[0]);
         chk_bit("R7", "tail after two edges", tail[1], old_t[1]);
         @(negedge clk);
         chk_bit("R7", "tail after three edges", tail[0], new_t[0]);
         chk_bit("R7", "tail after three edges", tail[1], new_t[1]);
      end
      idle(3);
      drive_lv(1'b0, 2'b00);

      // R6: reset in the middle of a sequence, seen before any clock edge
      for (int k = 0; k < 3; k++) begin
         set_data(1'b0, 2'b11, 2'b11);
         pulse(1'b1, '0, '0, "R6");
      end
      #1;
      rst_n = 1'b0;
      #0.5;
      chk_bit("R6", "tail[0] async clear", tail[0], 1'b0);
      chk_bit("R6", "tail[1] async clear", tail[1], 1'b0);
      chk_bit("R5", "tail_n[0] async clear", tail_n[0], 1'b1);
      clear_model();

      // R8: clock input high across reset release, data 1 on offer
      cp_common = 1'b1;
      cp_lane   = 2'b11;
      din_a     = 2'b11;
      din_b     = 2'b11;
      idle(3);
      rst_n = 1'b1;
      idle(8);
      push_exp("R8");
      idle(1);
      set_data(1'b0, 2'b00, 2'b00);
      cp_common = 1'b0;
      cp_lane   = 2'b00;
      idle(5);
      for (int k = 0; k < 8; k++) begin
         pulse(1'b1, '0, '0, "R8");
      end
      idle(3);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (200000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule